// File: doc/BRIEF.md
# Debug-Port Reset and Interrupt Command Logic

This block sits behind a four-wire test access port and turns instructions shifted in by an external debug host into two system-side effects. One instruction drives an internal chip reset, and a second instruction releases it. The reset stays on for as long as the host waits between the two, so the host sets the reset length. It must wait at least as long as a power-on reset pulse.

A third instruction places a one-bit request register between TDI and TDO. Shifting a 1 into that register and passing through Update-DR raises an interrupt request toward the CPU. In the default mode the request stays high until software writes 0 to it, so no request can be lost. The instruction also stays loaded until the host replaces it. The CPU takes the request with exception code 0x600, and its priority comes from a field held outside this block.

A build-time option selects a compatibility mode. In that mode, loading the interrupt instruction fires a pulse of fixed length on the peripheral clock, and the instruction register falls back to BYPASS on the next TCK edge. Everything driven by TCK crosses into the peripheral clock domain through two-flop synchronizers. The request bit lives in the peripheral domain and is synchronized back to TCK so that the host can read it.

Top module: `dbg_cmd_port`

## Requirements
- R1: After reset, sys_rst_o and irq_o are 0, and the instruction register holds BYPASS (0xFF). In BYPASS, a DR scan returns 0 on its first bit, and each later bit returns the TDI bit shifted one TCK earlier.
- R2: Capture-IR loads 0x01, which is shifted out LSB first. The instruction register changes only at Update-IR or in Test-Logic-Reset.
- R3: Loading 0x01 at Update-IR sets sys_rst_o within a few peripheral clocks. sys_rst_o stays high until 0x02 is loaded.
- R4: Any code other than 0x01, 0x02 or 0x03 selects the one-bit bypass path. Such a code leaves sys_rst_o unchanged.
- R5: With 0x03 loaded, an Update-DR whose last shifted bit is 1 raises irq_o. Loading 0x03 alone does not raise it.
- R6: In the default mode, irq_o stays high until a software write (sw_wr_i=1) with sw_wdata_i=0. A write with sw_wdata_i=1 has no effect.
- R7: With 0x03 loaded, Capture-DR loads the current request bit into the scan path.
- R8: In the default mode, 0x03 remains in the instruction register after it is used, so repeated DR scans keep reaching the request bit.
- R9: Asserting trst_ni, or walking the TAP to Test-Logic-Reset with TMS, releases sys_rst_o and loads BYPASS. Neither action changes a pending request.
- R10: With LEGACY_MODE=1, loading 0x03 produces an irq_o pulse of exactly PULSE_LEN peripheral clocks. The instruction register then reverts to BYPASS.
- R11: tdo_o is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| trst_ni | input | 1 | Asynchronous test reset, active low |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| pclk_i | input | 1 | Peripheral clock |
| prst_ni | input | 1 | Power-on reset, active low |
| sw_wr_i | input | 1 | Software write strobe for the request bit |
| sw_wdata_i | input | 1 | Software write data for the request bit |
| sys_rst_o | output | 1 | Command-driven chip reset, peripheral domain |
| irq_o | output | 1 | Interrupt request, peripheral domain |

## Verification
The assertions run on every cycle and cover four behaviours:
- the instruction register changes only at Update-IR or Test-Logic-Reset;
- the reset flag rises only on a reset-assert update, and both return to idle values in Test-Logic-Reset;
- the held request survives every cycle without a clearing write, and a clearing write drops it;
- a compatibility pulse never exceeds its length.

Only the bench scenarios can show the behaviours that span several clocks and both clock domains: the reset being held across unrelated commands, the capture value read back through TDO, the request surviving a TRST pulse, and the exact pulse width.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_RST_ON  = 8'h01;
    localparam logic [IR_W-1:0] OP_RST_OFF = 8'h02;
    localparam logic [IR_W-1:0] OP_IRQ     = 8'h03;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    // TCK-domain registers cleared by TRST
    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic [IR_W-1:0] ir_sr;
        logic            dr_sr;
        logic            rst_req;
    } tck_regs_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:      n = tms ? ST_TLR      : ST_RTI;
            ST_RTI:      n = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_DR:   n = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_IR:   n = tms ? ST_TLR      : ST_CAP_IR;
            ST_CAP_IR:   n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   n = tms ? ST_SEL_DR   : ST_RTI;
            default:     n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_cmd_pkg::*;
(
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tms_i,
    output tap_state_e state_o
);
    tap_state_e state_d, state_q;

    always_comb begin
        state_d = tap_next(state_q, tms_i);
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) state_q <= ST_TLR;
        else          state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/dbg_irq_pclk.sv
module dbg_irq_pclk #(
    parameter bit LEGACY_MODE = 1'b0,
    parameter int PULSE_LEN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic pclk_i,
    input  logic prst_ni,
    input  logic tgl_i,
    input  logic clr_i,
    output logic set_evt_o,
    output logic irq_o
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic tgl_s, tgl_prev_d, tgl_prev_q;

    dbg_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk_i (pclk_i),
        .rst_ni(prst_ni),
        .d_i   (tgl_i),
        .q_o   (tgl_s)
    );

    always_comb begin
        tgl_prev_d = tgl_s;
        set_evt_o  = tgl_s ^ tgl_prev_q;
    end

    always_ff @(posedge pclk_i or negedge prst_ni) begin
        if (!prst_ni) tgl_prev_q <= 1'b0;
        else          tgl_prev_q <= tgl_prev_d;
    end

    generate
        if (LEGACY_MODE) begin : g_pulse
            logic [CNT_W-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = cnt_q;
                if (set_evt_o)           cnt_d = CNT_W'(PULSE_LEN);
                else if (clr_i)          cnt_d = '0;
                else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
            end
            always_ff @(posedge pclk_i or negedge prst_ni) begin
                if (!prst_ni) cnt_q <= '0;
                else          cnt_q <= cnt_d;
            end
            assign irq_o = (cnt_q != '0);
        end else begin : g_held
            logic req_d, req_q;
            always_comb begin
                req_d = req_q;
                if (set_evt_o)   req_d = 1'b1;
                else if (clr_i)  req_d = 1'b0;
            end
            always_ff @(posedge pclk_i or negedge prst_ni) begin
                if (!prst_ni) req_q <= 1'b0;
                else          req_q <= req_d;
            end
            assign irq_o = req_q;
        end
    endgenerate
endmodule

// File: rtl/dbg_cmd_port.sv
module dbg_cmd_port
    import dbg_cmd_pkg::*;
#(
    parameter bit LEGACY_MODE = 1'b0,
    parameter int PULSE_LEN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic tck_i,
    input  logic trst_ni,
    input  logic tms_i,
    input  logic tdi_i,
    output logic tdo_o,
    input  logic pclk_i,
    input  logic prst_ni,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    output logic sys_rst_o,
    output logic irq_o
);
    tap_state_e tap_state;
    tck_regs_t  tq, td;
    logic       tgl_d, tgl_q;
    logic       irq_tck;
    logic       sel_irq;
    logic       irq_set_evt;
    logic       sw_clr;

    dbg_tap_fsm u_fsm (
        .tck_i  (tck_i),
        .trst_ni(trst_ni),
        .tms_i  (tms_i),
        .state_o(tap_state)
    );

    // TCK-domain next-state logic
    always_comb begin
        td      = tq;
        tgl_d   = tgl_q;
        sel_irq = (tq.ir == OP_IRQ);
        case (tap_state)
            ST_TLR: begin
                td.ir      = OP_BYPASS;
                td.rst_req = 1'b0;
            end
            ST_CAP_IR:   td.ir_sr = IR_CAPTURE;
            ST_SHIFT_IR: td.ir_sr = {tdi_i, tq.ir_sr[IR_W-1:1]};
            ST_UPD_IR: begin
                td.ir = tq.ir_sr;
                if (tq.ir_sr == OP_RST_ON)  td.rst_req = 1'b1;
                if (tq.ir_sr == OP_RST_OFF) td.rst_req = 1'b0;
                if (LEGACY_MODE && tq.ir_sr == OP_IRQ) tgl_d = ~tgl_q;
            end
            ST_CAP_DR:   td.dr_sr = sel_irq ? irq_tck : 1'b0;
            ST_SHIFT_DR: td.dr_sr = tdi_i;
            ST_UPD_DR: begin
                if (!LEGACY_MODE && sel_irq && tq.dr_sr) tgl_d = ~tgl_q;
            end
            default: ;
        endcase
        // compatibility mode: command decays to bypass once set
        if (LEGACY_MODE && sel_irq && tap_state != ST_UPD_IR && tap_state != ST_TLR)
            td.ir = OP_BYPASS;
    end

    always_comb begin
        case (tap_state)
            ST_SHIFT_IR: tdo_o = tq.ir_sr[0];
            ST_SHIFT_DR: tdo_o = tq.dr_sr;
            default:     tdo_o = 1'b0;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) begin
            tq.ir      <= OP_BYPASS;
            tq.ir_sr   <= '0;
            tq.dr_sr   <= 1'b0;
            tq.rst_req <= 1'b0;
        end else begin
            tq <= td;
        end
    end

    // set toggle survives TRST so a pending request is not disturbed
    always_ff @(posedge tck_i or negedge prst_ni) begin
        if (!prst_ni) tgl_q <= 1'b0;
        else          tgl_q <= tgl_d;
    end

    dbg_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk_i (pclk_i),
        .rst_ni(prst_ni),
        .d_i   (tq.rst_req),
        .q_o   (sys_rst_o)
    );

    dbg_sync #(.STAGES(SYNC_STAGES)) u_irq_back_sync (
        .clk_i (tck_i),
        .rst_ni(trst_ni),
        .d_i   (irq_o),
        .q_o   (irq_tck)
    );

    assign sw_clr = sw_wr_i & ~sw_wdata_i;

    dbg_irq_pclk #(
        .LEGACY_MODE(LEGACY_MODE),
        .PULSE_LEN  (PULSE_LEN),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_irq (
        .pclk_i   (pclk_i),
        .prst_ni  (prst_ni),
        .tgl_i    (tgl_q),
        .clr_i    (sw_clr),
        .set_evt_o(irq_set_evt),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/dbg_cmd_port_chk.sv
module dbg_cmd_port_chk
    import dbg_cmd_pkg::*;
#(
    parameter bit LEGACY_MODE = 1'b0,
    parameter int PULSE_LEN   = 8
) (
    input logic            tck_i,
    input logic            trst_ni,
    input logic            pclk_i,
    input logic            prst_ni,
    input tap_state_e      tap_state,
    input logic [IR_W-1:0] ir_q,
    input logic [IR_W-1:0] ir_sr,
    input logic            rst_req,
    input logic            sw_wr_i,
    input logic            sw_wdata_i,
    input logic            set_evt,
    input logic            irq_o
);
    logic [15:0] hi_cnt;

    always_ff @(posedge pclk_i or negedge prst_ni) begin
        if (!prst_ni) hi_cnt <= '0;
        else          hi_cnt <= irq_o ? hi_cnt + 16'd1 : 16'd0;
    end

    // R2
    ir_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (tap_state != ST_UPD_IR && tap_state != ST_TLR && !(LEGACY_MODE && ir_q == OP_IRQ))
        |=> $stable(ir_q));

    // R3
    rst_rise_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $rose(rst_req) |-> $past(tap_state == ST_UPD_IR && ir_sr == OP_RST_ON));

    // R9
    tlr_idle_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (tap_state == ST_TLR) |=> (!rst_req && ir_q == OP_BYPASS));

    // R5
    irq_set_chk: assert property (@(posedge pclk_i) disable iff (!prst_ni)
        set_evt |=> irq_o);

    // R6
    irq_hold_chk: assert property (@(posedge pclk_i) disable iff (!prst_ni)
        (!LEGACY_MODE && irq_o && !(sw_wr_i && !sw_wdata_i)) |=> irq_o);

    // R6
    irq_clr_chk: assert property (@(posedge pclk_i) disable iff (!prst_ni)
        (!LEGACY_MODE && sw_wr_i && !sw_wdata_i && !set_evt) |=> !irq_o);

    // R10
    pulse_len_chk: assert property (@(posedge pclk_i) disable iff (!prst_ni)
        (LEGACY_MODE && irq_o) |-> (hi_cnt < 16'(PULSE_LEN)));
endmodule

bind dbg_cmd_port dbg_cmd_port_chk #(
    .LEGACY_MODE(LEGACY_MODE),
    .PULSE_LEN  (PULSE_LEN)
) u_chk (
    .tck_i     (tck_i),
    .trst_ni   (trst_ni),
    .pclk_i    (pclk_i),
    .prst_ni   (prst_ni),
    .tap_state (tap_state),
    .ir_q      (tq.ir),
    .ir_sr     (tq.ir_sr),
    .rst_req   (tq.rst_req),
    .sw_wr_i   (sw_wr_i),
    .sw_wdata_i(sw_wdata_i),
    .set_evt   (irq_set_evt),
    .irq_o     (irq_o)
);

// File: tb/dbg_cmd_port_bench.sv
module dbg_cmd_port_bench;
    localparam int PULSE = 8;

    logic pclk = 1'b0;
    logic tck = 1'b0, trst_n = 1'b0, prst_n = 1'b0;
    logic tms = 1'b1, tdi = 1'b0;
    logic sw_wr = 1'b0, sw_wdata = 1'b0;
    logic tdo, tdo_l, sys_rst, sys_rst_l, irq, irq_l;
    logic tdo_cap, tdo_cap_l;
    int   n_total = 0, n_bad = 0;
    int   lg_hi = 0;
    bit   done = 1'b0;

    always #4 pclk = ~pclk;

    dbg_cmd_port u_dbg_cmd_port (
        .tck_i(tck), .trst_ni(trst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo),
        .pclk_i(pclk), .prst_ni(prst_n), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
        .sys_rst_o(sys_rst), .irq_o(irq)
    );

    dbg_cmd_port #(.LEGACY_MODE(1'b1), .PULSE_LEN(PULSE)) u_dbg_cmd_port_legacy (
        .tck_i(tck), .trst_ni(trst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo_l),
        .pclk_i(pclk), .prst_ni(prst_n), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
        .sys_rst_o(sys_rst_l), .irq_o(irq_l)
    );

    always @(posedge pclk) if (irq_l) lg_hi <= lg_hi + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        #20;
        tdo_cap = tdo; tdo_cap_l = tdo_l;
        tck = 1'b1;
        #20;
        tck = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [7:0] din, output logic [7:0] dout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, din[i]);
            dout[i] = tdo_cap;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [3:0] din,
                           output logic [3:0] dout, output logic [3:0] dout_l);
        dout = '0; dout_l = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = tdo_cap; dout_l[i] = tdo_cap_l;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic sw_write(input logic d);
        @(negedge pclk); sw_wr = 1'b1; sw_wdata = d;
        @(negedge pclk); sw_wr = 1'b0; sw_wdata = 1'b0;
        #20;
    endtask

    task automatic t_reset_state();
        logic [7:0] o; logic [3:0] q, ql;
        chk("R1 sys_rst after reset", sys_rst, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R11 tdo idle", tdo, 0);
        scan_ir(8'hFF, o);
        chk("R2 capture-IR value", o, 8'h01);
        scan_dr(2, 4'b0001, q, ql);
        chk("R1 bypass delay", q[1:0], 2'b10);
    endtask

    task automatic t_reset_cmd();
        logic [7:0] o; logic [3:0] q, ql;
        scan_ir(8'h01, o);
        #64;
        chk("R3 reset asserted", sys_rst, 1);
        idle(10);
        chk("R3 reset held", sys_rst, 1);
        scan_ir(8'h5A, o);
        #64;
        chk("R4 unknown code keeps reset", sys_rst, 1);
        scan_dr(3, 4'b0011, q, ql);
        chk("R4 unknown code bypass path", q[2:0], 3'b110);
        scan_ir(8'h02, o);
        #64;
        chk("R3 reset released", sys_rst, 0);
    endtask

    task automatic t_irq_sticky();
        logic [7:0] o; logic [3:0] q, ql;
        scan_ir(8'h03, o);
        #80;
        chk("R5 command alone no request", irq, 0);
        scan_dr(1, 4'b0001, q, ql);
        chk("R7 capture of idle bit", q[0], 0);
        #80;
        chk("R5 request raised", irq, 1);
        idle(4);
        scan_dr(1, 4'b0000, q, ql);
        chk("R8 command retained, capture bit", q[0], 1);
        #80;
        chk("R6 update with 0 keeps request", irq, 1);
        sw_write(1'b1);
        chk("R6 write 1 ignored", irq, 1);
        idle(20);
        chk("R6 request held", irq, 1);
        sw_write(1'b0);
        chk("R6 write 0 clears", irq, 0);
    endtask

    task automatic t_trst_tlr();
        logic [7:0] o; logic [3:0] q, ql;
        scan_dr(1, 4'b0001, q, ql);
        #80;
        chk("R5 request raised again", irq, 1);
        scan_ir(8'h01, o);
        #64;
        chk("R3 reset asserted again", sys_rst, 1);
        trst_n = 1'b0; #40; trst_n = 1'b1;
        step(0, 0);
        #64;
        chk("R9 trst releases reset", sys_rst, 0);
        chk("R9 trst keeps request", irq, 1);
        scan_dr(2, 4'b0001, q, ql);
        chk("R9 trst loads bypass", q[1:0], 2'b10);
        scan_ir(8'h01, o);
        #64;
        chk("R3 reset asserted third", sys_rst, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        #64;
        chk("R9 TLR releases reset", sys_rst, 0);
        chk("R9 TLR keeps request", irq, 1);
        sw_write(1'b0);
        chk("R6 final clear", irq, 0);
    endtask

    task automatic t_legacy();
        logic [7:0] o; logic [3:0] q, ql;
        int base;
        #200;
        base = lg_hi;
        scan_ir(8'h03, o);
        #400;
        chk("R10 pulse length", lg_hi - base, PULSE);
        chk("R10 pulse ended", irq_l, 0);
        scan_dr(2, 4'b0001, q, ql);
        chk("R10 command reverted to bypass", ql[1:0], 2'b10);
        #200;
        chk("R10 no further pulse", lg_hi - base, PULSE);
    endtask

    initial begin
        #100;
        trst_n = 1'b1; prst_n = 1'b1;
        #20;
        step(0, 0);
        t_reset_state();
        t_reset_cmd();
        t_irq_sticky();
        t_trst_tlr();
        t_legacy();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_total++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule